// File: doc/BRIEF.md
# Power-Saving Clock-Change Sequencer

This block runs the timed handshake that moves the system clock between full, half and 1/32 speed. Software writes a one-hot speed code into a control register. On a clean rising edge of exactly one code bit the block pulls an active-low freeze line. It then waits for the system devices to acknowledge the freeze, and walks through a chain of programmable delays. During that chain it drives a 3-line active-low clock-change bus and a PLL-bypass output, releases both, and finally lets go of the freeze.

Every delay is counted in cycles of the block clock. Software programs each delay through a write-only register port. A separate switch-latency count runs alongside the settle delay and marks, with a one-cycle pulse, the cycle in which the clock at the new speed is expected. When both the settle delay and the latency count have finished, the block goes idle and publishes the new speed on a status output. Programming the new speed into the processors and generating the clock itself are done elsewhere.

Top module: `clkstep_seq`

## Requirements
- R1: After reset, `freeze_n` is 1, `chg_n` is 3'b111, `pll_bypass` is 0, `clk_ready` is 0, `busy` is 0 and `cur_speed` is 0 (full speed); every delay register resets to 0.
- R2: Register addresses on `cfg_addr` are: 0 control, 1 change-assert delay (8 bit), 2 bypass-assert delay (16 bit), 3 bypass-hold delay (8 bit), 4 change-release delay (8 bit), 5 settle delay (32 bit) and 6 switch latency (32 bit). Speed codes in control bits [7:0] are 0x01 full, 0x02 half and 0x20 for 1/32. A control write whose code bits hold exactly one set bit, where that bit was 0 in the stored control value, starts a sequence when the block is idle. `freeze_n` falls and `busy` rises at the clock edge that captures the write.
- R3: A control write with more than one code bit set, or with none set, starts nothing. Bits under mask 0xDC are discarded.
- R4: A control write whose single code bit is already set in the stored control value starts nothing, because the bit did not go from 0 to 1.
- R5: The block waits for `freeze_ack`. Counting from the edge at which it is first sampled high, one `chg_n` line goes low after max(D,1) cycles, where D is the change-assert delay. Full speed drives line 0 low, half speed line 1, and 1/32 speed line 2.
- R6: `pll_bypass` rises max(D,1) cycles after `chg_n` is asserted, where D is the bypass-assert delay.
- R7: `pll_bypass` falls max(D,1) cycles after it rose, where D is the bypass-hold delay. `chg_n` then returns to 3'b111 max(D,1) cycles after that, where D is the change-release delay.
- R8: `freeze_n` returns to 1 max(D,1) cycles after `chg_n` is released, where D is the settle delay.
- R9: `clk_ready` is high for exactly one cycle, max(D,1) cycles after `chg_n` is released, where D is the switch latency.
- R10: One cycle after the later of the freeze release and the `clk_ready` pulse, `busy` falls. In the same cycle `cur_speed` takes the new speed, coded 0 full, 1 half, 2 for 1/32.
- R11: A valid start written while `busy` is high is ignored. The sequence in progress keeps its original target.
- R12: At most one `chg_n` line is low at a time. `pll_bypass` is high only while a `chg_n` line is low, and a `chg_n` line is low only while `freeze_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| freeze_ack | input | 1 | Freeze acknowledge from system devices |
| freeze_n | output | 1 | Active-low freeze request |
| chg_n | output | 3 | Active-low clock-change lines, one per speed |
| pll_bypass | output | 1 | PLL bypass request |
| clk_ready | output | 1 | One-cycle pulse when the new-speed clock is expected |
| busy | output | 1 | Sequence in progress |
| cur_speed | output | 2 | Current speed: 0 full, 1 half, 2 for 1/32 |

## Verification
On every cycle, the assertions check the output ordering rules: a single change line, bypass only inside a change window, change only inside freeze. They also check that idle means quiet outputs, that the ready pulse lasts one cycle, and that the published speed stays still during a sequence. The exact cycle distances between phases can only be shown by the bench scenarios, which time-stamp each output edge against the programmed delays. So can the start filtering: multi-bit codes, repeated codes and starts issued while busy.

// File: rtl/clkstep_pkg.sv
// Shared types for the clock-change sequencer.
// Assumes a single clock domain and a write-only register port.
package clkstep_pkg;

    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int ACT_W    = 8;
    localparam int ABT_W    = 16;
    localparam int DABT_W   = 8;
    localparam int DACT_W   = 8;
    localparam int PST_W    = 32;
    localparam int FSL_W    = 32;
    localparam int CNT_W    = 32;
    localparam int LINES    = 3;

    localparam logic [7:0] CODE_FULL  = 8'h01;
    localparam logic [7:0] CODE_HALF  = 8'h02;
    localparam logic [7:0] CODE_SLOW  = 8'h20;
    localparam logic [7:0] CODE_VALID = CODE_FULL | CODE_HALF | CODE_SLOW;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_ACT  = 3'd1,
        A_ABT  = 3'd2,
        A_DABT = 3'd3,
        A_DACT = 3'd4,
        A_PST  = 3'd5,
        A_FSL  = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        SPD_FULL = 2'd0,
        SPD_HALF = 2'd1,
        SPD_SLOW = 2'd2
    } speed_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRZ,
        ST_ACT,
        ST_ABT,
        ST_DABT,
        ST_DACT,
        ST_SETTLE
    } phase_e;

    typedef struct packed {
        logic [ACT_W-1:0]  act;
        logic [ABT_W-1:0]  abt;
        logic [DABT_W-1:0] dabt;
        logic [DACT_W-1:0] dact;
        logic [PST_W-1:0]  pst;
        logic [FSL_W-1:0]  fsl;
    } dly_cfg_t;

endpackage

// File: rtl/clkstep_regs.sv
// Register file and start filter for the clock-change sequencer.
// Holds the delay settings and the code bits of the control register,
// and raises a one-cycle start when a write makes exactly one code bit
// rise from 0 to 1. Assumes writes complete in one cycle.
module clkstep_regs
    import clkstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output dly_cfg_t          cfg,
    output logic              start,
    output speed_e            start_speed
);

    logic [7:0] ctrl_q;
    logic [7:0] code_new;
    logic       ctrl_wr;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign code_new = wr_data[7:0] & CODE_VALID;

    // Start when a control write holds one code bit that was clear before.
    assign start = ctrl_wr && $onehot(code_new) && ((code_new & ~ctrl_q) != 8'h00);

    // Map the one-hot code onto the speed encoding.
    always_comb begin
        case (code_new)
            CODE_FULL: start_speed = SPD_FULL;
            CODE_HALF: start_speed = SPD_HALF;
            default:   start_speed = SPD_SLOW;
        endcase
    end

    // Store the code bits and the delay settings on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg    <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: ctrl_q   <= code_new;
                A_ACT:  cfg.act  <= wr_data[ACT_W-1:0];
                A_ABT:  cfg.abt  <= wr_data[ABT_W-1:0];
                A_DABT: cfg.dabt <= wr_data[DABT_W-1:0];
                A_DACT: cfg.dact <= wr_data[DACT_W-1:0];
                A_PST:  cfg.pst  <= wr_data[PST_W-1:0];
                A_FSL:  cfg.fsl  <= wr_data[FSL_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/clkstep_dly.sv
// Loadable down-counter used for phase delays.
// After a load of N, done is high from the max(N,1)-th following cycle on,
// so the caller's next action lands max(N,1) edges after the load.
module clkstep_dly #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);

    logic [W-1:0] cnt;

    assign done = (cnt <= W'(1));

    // Load a new delay, or count down while running and not yet done.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && !done)
            cnt <= cnt - W'(1);
    end

endmodule

// File: rtl/clkstep_fsm.sv
// Phase sequencer: freeze, wait acknowledge, assert change, assert bypass,
// release bypass, release change, then settle and latency in parallel.
// All outputs are registered. Assumes the start pulse is only meaningful in idle.
module clkstep_fsm
    import clkstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  speed_e           start_speed,
    input  dly_cfg_t         cfg,
    input  logic             freeze_ack,
    input  logic             main_done,
    input  logic             lat_done,
    output logic             main_load,
    output logic [CNT_W-1:0] main_val,
    output logic             main_run,
    output logic             lat_load,
    output logic             lat_run,
    output logic             freeze_n,
    output logic [LINES-1:0] chg_n,
    output logic             pll_bypass,
    output logic             clk_ready,
    output logic             busy,
    output speed_e           cur_speed
);

    phase_e state;
    speed_e target;
    logic   settle_ok;
    logic   lat_ok;

    // Active-low line pattern for a target speed.
    function automatic logic [LINES-1:0] line_for(speed_e s);
        case (s)
            SPD_FULL: return 3'b110;
            SPD_HALF: return 3'b101;
            default:  return 3'b011;
        endcase
    endfunction

    assign busy     = (state != ST_IDLE);
    assign main_run = (state != ST_IDLE) && (state != ST_FRZ);
    assign lat_load = (state == ST_DACT) && main_done;
    assign lat_run  = (state == ST_SETTLE) && !lat_ok;

    // Pick the next delay to load at each phase boundary.
    always_comb begin
        main_load = 1'b0;
        main_val  = '0;
        case (state)
            ST_FRZ: if (freeze_ack) begin
                main_load = 1'b1;
                main_val  = CNT_W'(cfg.act);
            end
            ST_ACT: if (main_done) begin
                main_load = 1'b1;
                main_val  = CNT_W'(cfg.abt);
            end
            ST_ABT: if (main_done) begin
                main_load = 1'b1;
                main_val  = CNT_W'(cfg.dabt);
            end
            ST_DABT: if (main_done) begin
                main_load = 1'b1;
                main_val  = CNT_W'(cfg.dact);
            end
            ST_DACT: if (main_done) begin
                main_load = 1'b1;
                main_val  = CNT_W'(cfg.pst);
            end
            default: ;
        endcase
    end

    // Advance the phases and drive the registered handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            target     <= SPD_FULL;
            cur_speed  <= SPD_FULL;
            freeze_n   <= 1'b1;
            chg_n      <= '1;
            pll_bypass <= 1'b0;
            clk_ready  <= 1'b0;
            settle_ok  <= 1'b0;
            lat_ok     <= 1'b0;
        end else begin
            clk_ready <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    target   <= start_speed;
                    freeze_n <= 1'b0;
                    state    <= ST_FRZ;
                end
                ST_FRZ: if (freeze_ack) begin
                    state <= ST_ACT;
                end
                ST_ACT: if (main_done) begin
                    chg_n <= line_for(target);
                    state <= ST_ABT;
                end
                ST_ABT: if (main_done) begin
                    pll_bypass <= 1'b1;
                    state      <= ST_DABT;
                end
                ST_DABT: if (main_done) begin
                    pll_bypass <= 1'b0;
                    state      <= ST_DACT;
                end
                ST_DACT: if (main_done) begin
                    chg_n     <= '1;
                    settle_ok <= 1'b0;
                    lat_ok    <= 1'b0;
                    state     <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_ok && lat_ok) begin
                        cur_speed <= target;
                        state     <= ST_IDLE;
                    end else begin
                        if (!settle_ok && main_done) begin
                            freeze_n  <= 1'b1;
                            settle_ok <= 1'b1;
                        end
                        if (!lat_ok && lat_done) begin
                            clk_ready <= 1'b1;
                            lat_ok    <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/clkstep_seq.sv
// Top of the clock-change sequencer: register file, phase sequencer,
// a shared phase-delay counter and a parallel switch-latency counter.
// Assumes one clock domain with synchronous active-low reset.
module clkstep_seq
    import clkstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              freeze_ack,
    output logic              freeze_n,
    output logic [LINES-1:0]  chg_n,
    output logic              pll_bypass,
    output logic              clk_ready,
    output logic              busy,
    output logic [1:0]        cur_speed
);

    dly_cfg_t         cfg;
    logic             start;
    speed_e           start_speed;
    speed_e           speed_q;
    logic             main_load, main_run, main_done;
    logic [CNT_W-1:0] main_val;
    logic             lat_load, lat_run, lat_done;

    assign cur_speed = speed_q;

    clkstep_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .cfg         (cfg),
        .start       (start),
        .start_speed (start_speed)
    );

    clkstep_dly #(.W(CNT_W)) u_main_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (main_load),
        .load_val (main_val),
        .run      (main_run),
        .done     (main_done)
    );

    clkstep_dly #(.W(FSL_W)) u_lat_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (cfg.fsl),
        .run      (lat_run),
        .done     (lat_done)
    );

    clkstep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_speed (start_speed),
        .cfg         (cfg),
        .freeze_ack  (freeze_ack),
        .main_done   (main_done),
        .lat_done    (lat_done),
        .main_load   (main_load),
        .main_val    (main_val),
        .main_run    (main_run),
        .lat_load    (lat_load),
        .lat_run     (lat_run),
        .freeze_n    (freeze_n),
        .chg_n       (chg_n),
        .pll_bypass  (pll_bypass),
        .clk_ready   (clk_ready),
        .busy        (busy),
        .cur_speed   (speed_q)
    );

endmodule

// File: rtl/clkstep_seq_chk.sv
// Port-level checker for the clock-change sequencer, bound to the top.
// Checks output ordering and idle/busy rules on every cycle.
module clkstep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       freeze_n,
    input logic [2:0] chg_n,
    input logic       pll_bypass,
    input logic       clk_ready,
    input logic       busy,
    input logic [1:0] cur_speed
);

    // R12: never more than one change line low
    a_r12_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~chg_n));

    // R12: bypass only inside a change window
    a_r12_bypass_in_chg: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (chg_n != 3'b111));

    // R12: change only while frozen
    a_r12_chg_in_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_n != 3'b111) |-> !freeze_n);

    // R1: idle means quiet outputs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (freeze_n && (chg_n == 3'b111) && !pll_bypass && !clk_ready));

    // R2: a start pulls freeze at once
    a_r2_start_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !freeze_n);

    // R7: bypass drops before the change lines release
    a_r7_bypass_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_bypass) |-> (chg_n != 3'b111));

    // R8: freeze releases only after change lines are released
    a_r8_freeze_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_n) |-> (chg_n == 3'b111));

    // R9: ready is a single-cycle pulse
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ready |=> !clk_ready);

    // R10: published speed holds during a sequence and stays in range
    a_r10_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_speed));

    a_r10_speed_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_speed != 2'd3);

endmodule

bind clkstep_seq clkstep_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_n   (freeze_n),
    .chg_n      (chg_n),
    .pll_bypass (pll_bypass),
    .clk_ready  (clk_ready),
    .busy       (busy),
    .cur_speed  (cur_speed)
);

// File: tb/clkstep_seq_tb.sv
// Self-checking bench: vector table of full sequences, then directed cases.
module clkstep_seq_tb;

    typedef struct packed {
        logic [7:0]  code;
        logic [7:0]  act;
        logic [15:0] abt;
        logic [7:0]  dabt;
        logic [7:0]  dact;
        logic [31:0] pst;
        logic [31:0] fsl;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'd3, 16'd5,   8'd2, 8'd4, 32'd6,  32'd9},
        '{8'h02, 8'd0, 16'd1,   8'd0, 8'd1, 32'd10, 32'd2},
        '{8'h20, 8'd7, 16'd300, 8'd5, 8'd3, 32'd1,  32'd1},
        '{8'h02, 8'd1, 16'd2,   8'd9, 8'd0, 32'd4,  32'd4},
        '{8'h01, 8'd2, 16'd0,   8'd1, 8'd2, 32'd0,  32'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        freeze_ack = 1'b0;
    logic        freeze_n;
    logic [2:0]  chg_n;
    logic        pll_bypass;
    logic        clk_ready;
    logic        busy;
    logic [1:0]  cur_speed;

    int total = 0;
    int fails = 0;
    bit done_flag = 0;

    int cyc = 0;
    int t_ack, t_c1, t_c0, t_b1, t_b0, t_f1, t_r, t_i, n_rdy;
    logic [2:0] seen_line;
    logic p_ack = 0, p_byp = 0, p_frz = 1, p_rdy = 0, p_busy = 0;
    logic [2:0] p_chg = 3'b111;

    always #10 clk = ~clk;

    clkstep_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .freeze_ack (freeze_ack),
        .freeze_n   (freeze_n),
        .chg_n      (chg_n),
        .pll_bypass (pll_bypass),
        .clk_ready  (clk_ready),
        .busy       (busy),
        .cur_speed  (cur_speed)
    );

    // Time-stamp output edges just after each clock edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (freeze_ack && !p_ack) t_ack = cyc;
        if (chg_n != 3'b111 && p_chg == 3'b111) begin t_c1 = cyc; seen_line = chg_n; end
        if (chg_n == 3'b111 && p_chg != 3'b111) t_c0 = cyc;
        if (pll_bypass && !p_byp) t_b1 = cyc;
        if (!pll_bypass && p_byp) t_b0 = cyc;
        if (freeze_n && !p_frz) t_f1 = cyc;
        if (clk_ready) begin n_rdy++; if (!p_rdy) t_r = cyc; end
        if (!busy && p_busy) t_i = cyc;
        p_ack = freeze_ack; p_chg = chg_n; p_byp = pll_bypass;
        p_frz = freeze_n; p_rdy = clk_ready; p_busy = busy;
    end

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_stamps();
        t_ack = -1; t_c1 = -1; t_c0 = -1; t_b1 = -1; t_b0 = -1;
        t_f1 = -1; t_r = -1; t_i = -1; n_rdy = 0; seen_line = 3'b111;
    endtask

    function automatic int mx1(longint v);
        return (v < 1) ? 1 : int'(v);
    endfunction

    function automatic logic [2:0] exp_line(logic [7:0] c);
        return (c == 8'h01) ? 3'b110 : (c == 8'h02) ? 3'b101 : 3'b011;
    endfunction

    function automatic int exp_speed(logic [7:0] c);
        return (c == 8'h01) ? 0 : (c == 8'h02) ? 1 : 2;
    endfunction

    task automatic wait_idle();
        for (int g = 0; g < 5000 && busy; g++) @(negedge clk);
    endtask

    task automatic quiet_for(string req, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(req, "no start busy", busy, 0);
            chk(req, "no start freeze_n", freeze_n, 1);
        end
    endtask

    task automatic run_vec(vec_t v);
        wr(3'd1, 32'(v.act));
        wr(3'd2, 32'(v.abt));
        wr(3'd3, 32'(v.dabt));
        wr(3'd4, 32'(v.dact));
        wr(3'd5, v.pst);
        wr(3'd6, v.fsl);
        wr(3'd0, 32'h0);
        clear_stamps();
        wr(3'd0, 32'(v.code));
        chk("R2", "freeze_n after start", freeze_n, 0);
        chk("R2", "busy after start", busy, 1);
        repeat (3) @(negedge clk);
        chk("R5", "no change before ack", chg_n, 3'b111);
        freeze_ack = 1'b1;
        @(negedge clk);
        wait_idle();
        freeze_ack = 1'b0;
        chk("R5", "change after ack", t_c1 - t_ack, mx1(v.act));
        chk("R5", "change line", seen_line, exp_line(v.code));
        chk("R6", "bypass after change", t_b1 - t_c1, mx1(v.abt));
        chk("R7", "bypass hold", t_b0 - t_b1, mx1(v.dabt));
        chk("R7", "change release", t_c0 - t_b0, mx1(v.dact));
        chk("R8", "freeze release", t_f1 - t_c0, mx1(v.pst));
        chk("R9", "ready time", t_r - t_c0, mx1(v.fsl));
        chk("R9", "ready pulses", n_rdy, 1);
        chk("R10", "idle time", t_i - ((t_f1 > t_r) ? t_f1 : t_r), 1);
        chk("R10", "speed", cur_speed, exp_speed(v.code));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "freeze_n", freeze_n, 1);
        chk("R1", "chg_n", chg_n, 3'b111);
        chk("R1", "pll_bypass", pll_bypass, 0);
        chk("R1", "clk_ready", clk_ready, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "cur_speed", cur_speed, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4: same code bit written again, no 0-to-1 edge
        wr(3'd0, 32'h01);
        quiet_for("R4", 4);

        // R3: two code bits, reserved-only bits, mixed codes
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h03);
        quiet_for("R3", 3);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'hDC);
        quiet_for("R3", 3);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h21);
        quiet_for("R3", 3);

        // R11: second start while busy is ignored
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h0);
        clear_stamps();
        wr(3'd0, 32'h20);
        chk("R11", "first start busy", busy, 1);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h02);
        chk("R11", "still frozen", freeze_n, 0);
        freeze_ack = 1'b1;
        @(negedge clk);
        wait_idle();
        freeze_ack = 1'b0;
        chk("R11", "line kept", seen_line, 3'b011);
        chk("R11", "speed kept", cur_speed, 2);
        quiet_for("R11", 3);

        done_flag = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule